// File: doc/BRIEF.md
# UART Modem Control and Internal Loopback

This block holds the modem control register of one UART channel and drives the modem-side pins from it. A host bus writes and reads an 8-bit control word. The low bits set the active-low request-to-send, data-terminal-ready and general-purpose output pins. Bit 4 turns on an internal loopback test path. The upper bits choose a divide-by-4 input clock prescale, expose the extended trigger registers through a flag, and enable the Xon-any function. These upper bits change only while a separate enhanced-feature enable input is high.

In loopback the serial transmit stream from the shifter is fed straight back to the receiver input. The four low control bits appear on the modem status bits in a crossed order, and the external pins rest at their idle high levels. An automatic flow-control mode can take over the request-to-send pin. A small prescaler gives a one-cycle clock enable to the baud logic downstream, either on every cycle or on every fourth cycle.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the register reads 0x00, rts_n, dtr_n and every gpo_n pin are 1, loopback is off, and baud_ce is 1 on every cycle.
- R2: A write always loads bits 4..0 of the register. The new value reads back on rd_data from the cycle after the write edge.
- R3: A write loads bits 7..5 only when ext_feat_en is 1. When ext_feat_en is 0 those bits keep their previous value.
- R4: Outside loopback, with automatic RTS off, rts_n = NOT bit 1 and dtr_n = NOT bit 0. Every gpo_n pin equals NOT bit 3.
- R5: Outside loopback, with auto_rts_en = 1, rts_n = NOT flow_rts_req, and control bit 1 has no effect on the pin.
- R6: trig_access equals bit 6 and xon_any_en equals bit 5.
- R7: When bit 4 is 1, rx_ser_out equals tx_ser_in, tx_pin is held at 1, and rts_n, dtr_n and gpo_n are held at 1 whatever auto_rts_en and flow_rts_req are. Outside loopback tx_pin = tx_ser_in and rx_ser_out = rx_pin.
- R8: modem_stat[3:0] stands for status bits 7..4. In loopback it equals {bit 3, bit 2, bit 0, bit 1} of the register, and status_pins_n is ignored. Outside loopback it equals NOT status_pins_n.
- R9: With bit 7 at 0, baud_ce is 1 on every cycle. With bit 7 at 1, baud_ce pulses for one cycle in every four. When bit 7 turns to 1, the count restarts: the first pulse comes in the fifth cycle in which the new value is visible, and the next pulse four cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Write data |
| ext_feat_en | input | 1 | Enhanced-feature enable; 1 opens bits 7..5 to writes |
| auto_rts_en | input | 1 | 1 gives the RTS pin to the flow-control engine |
| flow_rts_req | input | 1 | Flow-control RTS request, 1 = assert (pin low) |
| tx_ser_in | input | 1 | Serial data from the transmit shifter |
| rx_pin | input | 1 | External receive pin |
| status_pins_n | input | 4 | External active-low modem status inputs, index 3 maps to status bit 7 |
| rd_data | output | 8 | Register readback |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| gpo_n | output | 2 | General-purpose output pins, active low |
| tx_pin | output | 1 | External transmit pin |
| rx_ser_out | output | 1 | Serial data to the receive shifter |
| modem_stat | output | 4 | Modem status bits 7..4, active high |
| xon_any_en | output | 1 | Xon-any function enable |
| trig_access | output | 1 | Enables access to the transmit-control and trigger-level registers |
| baud_ce | output | 1 | Prescaled clock enable |

## Verification
A wrong register bit shows at the ports one cycle after the write edge. It appears on rd_data and also on the pin or status bit that the bit drives, so the scoreboard compares every output in that cycle. A gate that admits upper-bit writes while ext_feat_en is low shows as a changed readback and a changed trig_access or xon_any_en. A wrong loopback mapping shows at once on modem_stat, because each control bit is toggled on its own. A prescaler count that is not restarted, or is off by one, moves the first baud_ce pulse after the switch by at least one cycle. The bench checks the enable in every cycle for a dozen cycles, so such a fault cannot hide.

// File: rtl/uart_mc_pkg.sv
package uart_mc_pkg;
    // Control word, bit 7 first.
    typedef struct packed {
        logic clk_div4;     // bit 7
        logic trig_access;  // bit 6
        logic xon_any;      // bit 5
        logic loopback;     // bit 4
        logic gpo;          // bit 3
        logic fifo_rdy;     // bit 2
        logic rts;          // bit 1
        logic dtr;          // bit 0
    } mcr_t;

    localparam int unsigned MCR_W    = 8;
    localparam int unsigned LOCK_LSB = 5;
endpackage

// File: rtl/mcr_reg.sv
module mcr_reg
    import uart_mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [MCR_W-1:0] wr_data,
    input  logic             feat_en,
    output mcr_t             ctrl
);
    typedef struct packed {
        logic [MCR_W-1:0] word;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < int'(MCR_W); i++) begin
                if (i < int'(LOCK_LSB) || feat_en)
                    st_d.word[i] = wr_data[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = mcr_t'(st_q.word);

    // R3: locked upper bits keep their value
    p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !feat_en) |=> (ctrl[MCR_W-1:LOCK_LSB] == $past(ctrl[MCR_W-1:LOCK_LSB])));
    // R2: low bits always take the written value
    p_lower_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl[LOCK_LSB-1:0] == $past(wr_data[LOCK_LSB-1:0])));
    // R3: with the gate open the upper bits load
    p_upper_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && feat_en) |=> (ctrl[MCR_W-1:LOCK_LSB] == $past(wr_data[MCR_W-1:LOCK_LSB])));
endmodule

// File: rtl/mcr_prescaler.sv
module mcr_prescaler #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_div,
    output logic ce
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sel;
    } ps_state_t;

    ps_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sel = sel_div;
        if (sel_div != st_q.sel)     st_d.cnt = '0;
        else if (st_q.cnt == LAST)   st_d.cnt = '0;
        else                         st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ce = sel_div ? (st_q.sel && st_q.cnt == LAST) : 1'b1;

    // R9: no back-to-back enables while dividing
    p_ce_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_div && $past(sel_div) && ce) |-> !$past(ce));
    // R9: count restarts, so no enable in the first divided cycle
    p_ce_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_div) |-> !ce);
endmodule

// File: rtl/mcr_pin_mux.sv
module mcr_pin_mux
    import uart_mc_pkg::*;
#(
    parameter int unsigned NUM_GPO = 2
) (
    input  mcr_t               ctrl,
    input  logic               auto_rts_en,
    input  logic               flow_rts_req,
    input  logic               tx_ser_in,
    input  logic               rx_pin,
    input  logic [3:0]         status_pins_n,
    output logic               rts_n,
    output logic               dtr_n,
    output logic [NUM_GPO-1:0] gpo_n,
    output logic               tx_pin,
    output logic               rx_ser_out,
    output logic [3:0]         modem_stat
);
    logic loop;
    assign loop = ctrl.loopback;

    always_comb begin
        if (loop) begin
            tx_pin     = 1'b1;
            rx_ser_out = tx_ser_in;
            rts_n      = 1'b1;
            dtr_n      = 1'b1;
            modem_stat = {ctrl.gpo, ctrl.fifo_rdy, ctrl.dtr, ctrl.rts};
        end else begin
            tx_pin     = tx_ser_in;
            rx_ser_out = rx_pin;
            rts_n      = auto_rts_en ? !flow_rts_req : !ctrl.rts;
            dtr_n      = !ctrl.dtr;
            modem_stat = ~status_pins_n;
        end
    end

    for (genvar g = 0; g < int'(NUM_GPO); g++) begin : g_gpo
        assign gpo_n[g] = loop | !ctrl.gpo;
    end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import uart_mc_pkg::*;
#(
    parameter int unsigned NUM_GPO = 2,
    parameter int unsigned DIV     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               ext_feat_en,
    input  logic               auto_rts_en,
    input  logic               flow_rts_req,
    input  logic               tx_ser_in,
    input  logic               rx_pin,
    input  logic [3:0]         status_pins_n,
    output logic [7:0]         rd_data,
    output logic               rts_n,
    output logic               dtr_n,
    output logic [NUM_GPO-1:0] gpo_n,
    output logic               tx_pin,
    output logic               rx_ser_out,
    output logic [3:0]         modem_stat,
    output logic               xon_any_en,
    output logic               trig_access,
    output logic               baud_ce
);
    mcr_t ctrl;

    mcr_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .feat_en (ext_feat_en),
        .ctrl    (ctrl)
    );

    mcr_prescaler #(.DIV(DIV)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_div (ctrl.clk_div4),
        .ce      (baud_ce)
    );

    mcr_pin_mux #(.NUM_GPO(NUM_GPO)) u_mux (
        .ctrl          (ctrl),
        .auto_rts_en   (auto_rts_en),
        .flow_rts_req  (flow_rts_req),
        .tx_ser_in     (tx_ser_in),
        .rx_pin        (rx_pin),
        .status_pins_n (status_pins_n),
        .rts_n         (rts_n),
        .dtr_n         (dtr_n),
        .gpo_n         (gpo_n),
        .tx_pin        (tx_pin),
        .rx_ser_out    (rx_ser_out),
        .modem_stat    (modem_stat)
    );

    assign rd_data     = ctrl;
    assign xon_any_en  = ctrl.xon_any;
    assign trig_access = ctrl.trig_access;

    // R7: loopback isolates the line
    p_loop_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> (tx_pin && rx_ser_out == tx_ser_in && rts_n && dtr_n && (&gpo_n)));
    // R8: crossed status mapping in loopback
    p_loop_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> (modem_stat == {rd_data[3], rd_data[2], rd_data[0], rd_data[1]}));
    // R5: automatic RTS follows the flow-control request
    p_auto_rts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && !rd_data[4]) |-> (rts_n == !flow_rts_req));
    // R4: DTR pin is the inverse of its bit outside loopback
    p_dtr_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[4] |-> (dtr_n == !rd_data[0]));
    // R9: undivided clock gives an enable every cycle
    p_ce_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[7] |-> baud_ce);
endmodule

// File: tb/uart_modem_ctl_test.sv
module uart_modem_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ext_feat_en = 1'b0;
    logic       auto_rts_en = 1'b0;
    logic       flow_rts_req = 1'b0;
    logic       tx_ser_in = 1'b0;
    logic       rx_pin = 1'b1;
    logic [3:0] status_pins_n = 4'hF;
    logic [7:0] rd_data;
    logic       rts_n, dtr_n, tx_pin, rx_ser_out, xon_any_en, trig_access, baud_ce;
    logic [1:0] gpo_n;
    logic [3:0] modem_stat;

    always #10 clk = ~clk;  // 50 MHz

    uart_modem_ctl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ext_feat_en(ext_feat_en), .auto_rts_en(auto_rts_en),
        .flow_rts_req(flow_rts_req), .tx_ser_in(tx_ser_in), .rx_pin(rx_pin),
        .status_pins_n(status_pins_n), .rd_data(rd_data), .rts_n(rts_n),
        .dtr_n(dtr_n), .gpo_n(gpo_n), .tx_pin(tx_pin), .rx_ser_out(rx_ser_out),
        .modem_stat(modem_stat), .xon_any_en(xon_any_en),
        .trig_access(trig_access), .baud_ce(baud_ce)
    );

    // Observed vector: {rd(8), rts_n, dtr_n, gpo_n(2), tx_pin, rx_ser_out, stat(4), xon, trig, ce}
    typedef struct {
        string       tag;
        logic [20:0] exp;
        logic [20:0] mask;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [7:0] mreg = '0;

    localparam logic [20:0] M_NO_CE = 21'h1FFFFE;
    localparam logic [20:0] M_CE    = 21'h000001;

    function automatic logic [20:0] observe();
        return {rd_data, rts_n, dtr_n, gpo_n, tx_pin, rx_ser_out, modem_stat,
                xon_any_en, trig_access, baud_ce};
    endfunction

    function automatic logic [20:0] model(logic [7:0] m);
        logic lp;
        logic r, d, tp, rx;
        logic [1:0] g;
        logic [3:0] st;
        lp = m[4];
        if (lp) begin
            r = 1'b1; d = 1'b1; g = 2'b11; tp = 1'b1; rx = tx_ser_in;
            st = {m[3], m[2], m[0], m[1]};
        end else begin
            r  = auto_rts_en ? !flow_rts_req : !m[1];
            d  = !m[0];
            g  = {2{!m[3]}};
            tp = tx_ser_in;
            rx = rx_pin;
            st = ~status_pins_n;
        end
        return {m, r, d, g, tp, rx, st, m[5], m[6], 1'b1};
    endfunction

    // Monitor: pops one expectation per cycle and compares at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [20:0] obs;
            it  = q.pop_front();
            obs = observe();
            n_checks++;
            if ((obs & it.mask) !== (it.exp & it.mask)) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h (mask %h)",
                         it.tag, obs & it.mask, it.exp & it.mask, it.mask);
            end
        end
    end

    task automatic push(string tag, logic [20:0] e, logic [20:0] m);
        item_t it;
        it.tag = tag; it.exp = e; it.mask = m;
        q.push_back(it);
    endtask

    task automatic drain();
        wait (q.size() == 0);
        @(posedge clk); #1;
    endtask

    // Write lands at the posedge; returns just after it
    task automatic wr(logic [7:0] d, logic feat);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; ext_feat_en = feat;
        @(posedge clk); #1;
        wr_en = 1'b0; ext_feat_en = 1'b0;
        mreg = {feat ? d[7:5] : mreg[7:5], d[4:0]};
    endtask

    task automatic chk(string tag);
        push(tag, model(mreg), M_NO_CE);
        drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state including baud_ce
        push("R1 reset", {8'h00, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b1}, 21'h1FFFFF);
        drain();

        // R2/R4: low bits, pins follow
        wr(8'h01, 1'b0); chk("R4 dtr");
        wr(8'h02, 1'b0); chk("R4 rts");
        wr(8'h08, 1'b0); chk("R4 gpo");
        wr(8'h0F, 1'b0); chk("R2 low bits");

        // R3: locked upper bits
        wr(8'hE0, 1'b0); chk("R3 locked");
        wr(8'hE0, 1'b1); chk("R3 open");
        wr(8'h00, 1'b0); chk("R3 hold after low write");
        // R6: flags individually
        wr(8'h40, 1'b1); chk("R6 trig flag");
        wr(8'h20, 1'b1); chk("R6 xon flag");

        // R5: automatic RTS
        wr(8'h02, 1'b1);
        auto_rts_en = 1'b1; flow_rts_req = 1'b0; chk("R5 auto rts off");
        flow_rts_req = 1'b1; chk("R5 auto rts on");
        wr(8'h00, 1'b0); chk("R5 bit ignored");
        auto_rts_en = 1'b0; flow_rts_req = 1'b0;

        // R7/R8: loopback, toggling each control bit alone
        status_pins_n = 4'b1010; rx_pin = 1'b0; tx_ser_in = 1'b1;
        chk("R8 normal status");
        wr(8'h10, 1'b0); chk("R7 loopback idle");
        tx_ser_in = 1'b0; chk("R7 loopback data");
        wr(8'h11, 1'b0); chk("R8 dtr to bit5");
        wr(8'h12, 1'b0); chk("R8 rts to bit4");
        wr(8'h14, 1'b0); chk("R8 bit2 to bit6");
        wr(8'h18, 1'b0); chk("R8 gpo to bit7");
        status_pins_n = 4'b0000; chk("R8 pins ignored");
        auto_rts_en = 1'b1; flow_rts_req = 1'b1; wr(8'h1F, 1'b0); chk("R7 pins held");
        auto_rts_en = 1'b0; flow_rts_req = 1'b0;
        wr(8'h00, 1'b1); tx_ser_in = 1'b1; chk("R7 normal path");

        // R9: prescaler
        wr(8'h80, 1'b1);
        for (int k = 0; k < 13; k++)
            push("R9 div4", {20'h0, (k > 0 && k % 4 == 0)}, M_CE);
        drain();
        wr(8'h00, 1'b1);
        for (int k = 0; k < 4; k++) push("R9 undivided", 21'h1, M_CE);
        drain();
        wr(8'h80, 1'b1);
        @(posedge clk); #1;
        wr(8'h00, 1'b1);
        wr(8'h80, 1'b1);
        for (int k = 0; k < 9; k++)
            push("R9 restart", {20'h0, (k > 0 && k % 4 == 0)}, M_CE);
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule